// File: doc/BRIEF.md
# Preemptive Priority Message Multiplexer

This block merges five message sources into a single 64-bit transmit word stream under a fixed priority. Sources are ranked from highest to lowest as trigger pulse, link acknowledge, general-purpose I/O, video, and command. Arbitration runs on every word. When a more urgent source has a word available, it takes the next output slot, even if a less urgent message is only partly sent. The interrupted source is simply not accepted during that time. It keeps its place in its own message and continues once nothing more urgent is waiting. Interruptions can be nested, and the most urgent unfinished message always continues first.

Every output word carries a 3-bit tag naming its source. It also carries three markers:
- a start marker for the first word of a message,
- an end marker for the last word,
- a continuation marker for the first word sent after a message was interrupted.

The receiver uses these markers to rebuild each message. The trigger and I/O sources do not send streams. They raise a one-cycle strobe together with a data word, and each strobe is a complete one-word message. A one-entry hold register per strobe source keeps the word until it wins arbitration. When no word is available, the block sends an idle word.

Top module: `prio_msg_mux`

## Requirements
- R1: While reset is asserted and after its release with no input, `out_valid` is 0, `out_data` is the idle word 64'h0707070707070707, and `out_tag`, `out_sop`, `out_eop` and `out_cont` are 0.
- R2: In each cycle the block accepts one word from the available source with the lowest index. Index 0 is trigger, 1 is acknowledge, 2 is I/O, 3 is video and 4 is command. The accepted word appears on the output one clock later.
- R3: Preemption happens only at word boundaries. A stream source (index 1, 3 or 4) sees `src_ready` high only in a cycle where it is the accepted source. At most one stream source is ready in any cycle.
- R4: Each source's words leave the block exactly once and in the order they were offered, even when a message is interrupted, nested or resumed.
- R5: `out_sop` is 1 exactly on the first word of a message. `out_eop` is 1 exactly on its last word. For stream sources the last word is the one offered with `src_last` high.
- R6: `out_cont` is 1 exactly on a word that is not the first of its message and whose previous valid output word came from another source. `out_cont` and `out_sop` are never both 1.
- R7: In a cycle after which no word was accepted, the output shows the idle word with `out_valid` 0, tag 0 and all markers 0.
- R8: For a strobe source (index 0 or 2), `src_valid` is a strobe whose word is captured in a hold register. The word goes out as a one-word message, with `out_sop` and `out_eop` both 1, no earlier than two clocks after the strobe. `src_last` of a strobe source has no effect.
- R9: A strobe that arrives while the source's held word is neither empty nor leaving in that cycle is ignored. The held word goes out unchanged and the new word never appears.
- R10: `out_tag` equals the index of the source that supplied the word, as a 3-bit value below 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 5 | Per source: word available (stream) or strobe (indices 0 and 2) |
| src_last | input | 5 | Per source: offered word ends its message (stream sources only) |
| src_data | input | 320 | Per source 64-bit word, source i in bits [64*i+63:64*i] |
| src_ready | output | 5 | Stream source: word accepted this cycle; strobe source: hold can take a strobe |
| out_valid | output | 1 | Output word carries data |
| out_data | output | 64 | Output word or idle word |
| out_tag | output | 3 | Source index of the output word |
| out_sop | output | 1 | First word of a message |
| out_eop | output | 1 | Last word of a message |
| out_cont | output | 1 | First word sent after an interruption |

## Verification
Three events can coincide in one cycle:
- a strobe source's held word can leave while a new strobe arrives for the same source;
- an unfinished stream message can be preempted while a more urgent one begins;
- that preempted message can resume while another source's word was the previous one sent.

The bench causes all three by holding every one of the 32 availability patterns for several cycles, and then by random availability at three densities. A bench model of the hold registers, the per-source word positions and the last sent source predicts every output word's tag, data and markers. Each output word is compared with the model one cycle after acceptance.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
    localparam int unsigned PMUX_SRC_TRIG = 0;
    localparam int unsigned PMUX_SRC_ACK  = 1;
    localparam int unsigned PMUX_SRC_GPIO = 2;
    localparam int unsigned PMUX_SRC_VID  = 3;
    localparam int unsigned PMUX_SRC_CMD  = 4;
    localparam int unsigned PMUX_NSRC     = 5;
    localparam logic [63:0] PMUX_IDLE     = 64'h0707070707070707;
endpackage

// File: rtl/pmux_strobe_hold.sv
module pmux_strobe_hold #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [DATA_W-1:0] stb_data,
    input  logic              take,
    output logic              held_v,
    output logic [DATA_W-1:0] held_data
);
    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (stb && (!h_q.v || take)) begin
            h_d.v    = 1'b1;
            h_d.data = stb_data;
        end else if (take) begin
            h_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign held_v    = h_q.v;
    assign held_data = h_q.data;
endmodule

// File: rtl/pmux_prio_pick.sv
module pmux_prio_pick #(
    parameter int unsigned N = 5,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt[i]    = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_msg_mux.sv
module prio_msg_mux
    import pmux_pkg::*;
#(
    parameter int unsigned        NSRC      = PMUX_NSRC,
    parameter int unsigned        DATA_W    = 64,
    parameter logic [NSRC-1:0]    STB_MASK  = NSRC'((1 << PMUX_SRC_TRIG) | (1 << PMUX_SRC_GPIO)),
    parameter logic [DATA_W-1:0]  IDLE_WORD = DATA_W'(PMUX_IDLE),
    localparam int unsigned       TAG_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        src_valid,
    input  logic [NSRC-1:0]        src_last,
    input  logic [NSRC*DATA_W-1:0] src_data,
    output logic [NSRC-1:0]        src_ready,
    output logic                   out_valid,
    output logic [DATA_W-1:0]      out_data,
    output logic [TAG_W-1:0]       out_tag,
    output logic                   out_sop,
    output logic                   out_eop,
    output logic                   out_cont
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
        logic              sop;
        logic              eop;
        logic              cont;
        logic [NSRC-1:0]   inprog;
        logic [TAG_W-1:0]  prev_tag;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0]   avail;
    logic [NSRC-1:0]   word_last;
    logic [DATA_W-1:0] word [NSRC];
    logic [NSRC-1:0]   gnt;
    logic [TAG_W-1:0]  win_idx;
    logic              win_any;

    // Per-source front end: strobe sources get a one-word hold register,
    // stream sources are passed straight to the arbiter.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (STB_MASK[i]) begin : g_stb
            logic              hv;
            logic [DATA_W-1:0] hd;
            pmux_strobe_hold #(.DATA_W(DATA_W)) u_hold (
                .clk      (clk),
                .rst_n    (rst_n),
                .stb      (src_valid[i]),
                .stb_data (src_data[i*DATA_W +: DATA_W]),
                .take     (gnt[i]),
                .held_v   (hv),
                .held_data(hd)
            );
            assign avail[i]     = hv;
            assign word[i]      = hd;
            assign word_last[i] = 1'b1;
            assign src_ready[i] = ~hv | gnt[i];
        end else begin : g_stream
            assign avail[i]     = src_valid[i];
            assign word[i]      = src_data[i*DATA_W +: DATA_W];
            assign word_last[i] = src_last[i];
            assign src_ready[i] = gnt[i];
        end
    end

    pmux_prio_pick #(.N(NSRC)) u_pick (
        .req(avail),
        .gnt(gnt),
        .idx(win_idx),
        .any(win_any)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.data  = IDLE_WORD;
        st_d.tag   = '0;
        st_d.sop   = 1'b0;
        st_d.eop   = 1'b0;
        st_d.cont  = 1'b0;
        if (win_any) begin
            st_d.valid    = 1'b1;
            st_d.data     = '0;
            st_d.tag      = win_idx;
            st_d.prev_tag = win_idx;
            for (int i = 0; i < NSRC; i++) begin
                if (gnt[i]) begin
                    st_d.data      = word[i];
                    st_d.eop       = word_last[i];
                    st_d.sop       = ~st_q.inprog[i];
                    st_d.cont      = st_q.inprog[i] & (st_q.prev_tag != TAG_W'(i));
                    st_d.inprog[i] = ~word_last[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.data     <= IDLE_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_tag   = st_q.tag;
    assign out_sop   = st_q.sop;
    assign out_eop   = st_q.eop;
    assign out_cont  = st_q.cont;
endmodule

// File: rtl/pmux_checker.sv
module pmux_checker #(
    parameter int unsigned       NSRC      = 5,
    parameter int unsigned       DATA_W    = 64,
    parameter logic [NSRC-1:0]   STB_MASK  = '0,
    parameter logic [DATA_W-1:0] IDLE_WORD = '0,
    localparam int unsigned      TAG_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NSRC-1:0]        src_valid,
    input logic [NSRC-1:0]        src_last,
    input logic [NSRC-1:0]        src_ready,
    input logic                   out_valid,
    input logic [DATA_W-1:0]      out_data,
    input logic [TAG_W-1:0]       out_tag,
    input logic                   out_sop,
    input logic                   out_eop,
    input logic                   out_cont
);
    logic [NSRC-1:0] stream_ready;
    logic [NSRC-1:0] stream_take;
    logic            strobe_tag;

    assign stream_ready = src_ready & ~STB_MASK;
    assign stream_take  = stream_ready & src_valid;
    assign strobe_tag   = ((STB_MASK >> out_tag) & NSRC'(1)) != '0;

    a_r3_one_stream_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stream_ready));

    a_r2_accept_shows_next: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_take != '0) |=> out_valid);

    a_r7_idle_word: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == IDLE_WORD && !out_sop && !out_eop && !out_cont && out_tag == '0));

    a_r6_cont_not_sop: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cont) |-> !out_sop);

    a_r10_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tag < TAG_W'(NSRC)));

    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && strobe_tag) |-> (out_sop && out_eop && !out_cont));

    a_r5_last_gives_eop: assert property (@(posedge clk) disable iff (!rst_n)
        ((stream_take & src_last) != '0) |=> (out_valid && out_eop));

    for (genvar k = 1; k < NSRC; k++) begin : g_prio
        if (!STB_MASK[k]) begin : g_chk
            localparam logic [NSRC-1:0] LOWER = NSRC'((1 << k) - 1) & ~STB_MASK;
            a_r3_no_higher_waiting: assert property (@(posedge clk) disable iff (!rst_n)
                src_ready[k] |-> ((src_valid & LOWER) == '0));
        end
    end
endmodule

bind prio_msg_mux pmux_checker #(
    .NSRC     (NSRC),
    .DATA_W   (DATA_W),
    .STB_MASK (STB_MASK),
    .IDLE_WORD(IDLE_WORD)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_valid(src_valid),
    .src_last (src_last),
    .src_ready(src_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_tag  (out_tag),
    .out_sop  (out_sop),
    .out_eop  (out_eop),
    .out_cont (out_cont)
);

// File: tb/prio_msg_mux_tb.sv
module prio_msg_mux_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 5;
    localparam logic [4:0] STB = 5'b00101;
    localparam logic [63:0] IDLE = 64'h0707070707070707;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    src_valid = '0;
    logic [4:0]    src_last = '0;
    logic [319:0]  src_data = '0;
    logic [4:0]    src_ready;
    logic          out_valid;
    logic [63:0]   out_data;
    logic [2:0]    out_tag;
    logic          out_sop, out_eop, out_cont;

    int total = 0;
    int bad = 0;

    // bench model
    int          widx [NS];
    int          mno  [NS];
    int          mlen [NS];
    int          sno  [NS];
    bit          pend [NS];
    logic [63:0] pdat [NS];
    int          prev_tag = -1;

    logic        e_valid = 1'b0;
    logic [63:0] e_data  = IDLE;
    logic [2:0]  e_tag   = '0;
    logic        e_sop = 1'b0, e_eop = 1'b0, e_cont = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_msg_mux u_dut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_last(src_last),
        .src_data(src_data), .src_ready(src_ready), .out_valid(out_valid),
        .out_data(out_data), .out_tag(out_tag), .out_sop(out_sop),
        .out_eop(out_eop), .out_cont(out_cont)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    function automatic int len_of(input int src, input int n);
        return 1 + ((n * 7 + src * 3) % 6);
    endfunction

    task automatic check_out();
        if (e_valid) begin
            chk(out_valid == 1'b1, "R2 valid", 64'(out_valid), 64'(1));
            chk(out_tag == e_tag, "R2/R10 tag", 64'(out_tag), 64'(e_tag));
            chk(out_data == e_data, "R4/R8/R9 data", out_data, e_data);
            chk(out_sop == e_sop, "R5 sop", 64'(out_sop), 64'(e_sop));
            chk(out_eop == e_eop, "R5/R8 eop", 64'(out_eop), 64'(e_eop));
            chk(out_cont == e_cont, "R6 cont", 64'(out_cont), 64'(e_cont));
        end else begin
            chk(out_valid == 1'b0 && out_data == IDLE && out_tag == 3'd0 &&
                !out_sop && !out_eop && !out_cont, "R7 idle word", out_data, IDLE);
        end
    endtask

    // One cycle: check result of previous cycle, drive new inputs, predict.
    task automatic step(input logic [4:0] vmask);
        int w;
        @(negedge clk);
        check_out();
        w = -1;
        for (int i = 0; i < NS; i++) begin
            logic [63:0] nd;
            if (STB[i]) begin
                nd = {8'(8'h80 | i), 24'(sno[i]), 32'hC0DE0000};
                src_last[i] = 1'b0;
            end else begin
                nd = {8'(i), 24'(mno[i]), 32'(widx[i])};
                src_last[i] = (widx[i] == mlen[i] - 1);
            end
            src_data[i*64 +: 64] = nd;
            src_valid[i] = vmask[i];
            if (w < 0 && (STB[i] ? pend[i] : vmask[i])) w = i;
        end
        if (w < 0) begin
            e_valid = 1'b0; e_data = IDLE; e_tag = '0;
            e_sop = 1'b0; e_eop = 1'b0; e_cont = 1'b0;
        end else begin
            e_valid = 1'b1;
            e_tag = 3'(w);
            if (STB[w]) begin
                e_data = pdat[w]; e_sop = 1'b1; e_eop = 1'b1; e_cont = 1'b0;
            end else begin
                e_data = {8'(w), 24'(mno[w]), 32'(widx[w])};
                e_sop = (widx[w] == 0);
                e_eop = (widx[w] == mlen[w] - 1);
                e_cont = (widx[w] != 0) && (prev_tag != w);
            end
            prev_tag = w;
        end
        for (int i = 0; i < NS; i++) begin
            if (STB[i]) begin
                if (vmask[i] && (!pend[i] || w == i)) begin
                    pend[i] = 1'b1;
                    pdat[i] = {8'(8'h80 | i), 24'(sno[i]), 32'hC0DE0000};
                end else if (w == i) begin
                    pend[i] = 1'b0;
                end
                if (vmask[i]) sno[i]++;
            end else if (w == i) begin
                if (widx[i] == mlen[i] - 1) begin
                    widx[i] = 0;
                    mno[i]++;
                    mlen[i] = len_of(i, mno[i]);
                end else begin
                    widx[i]++;
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=%h exp=%h", 64'(0), 64'(1));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            widx[i] = 0; mno[i] = 0; mlen[i] = len_of(i, 0);
            sno[i] = 0; pend[i] = 1'b0; pdat[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0 && out_data == IDLE && out_tag == 3'd0 &&
            !out_sop && !out_eop && !out_cont, "R1 reset state", out_data, IDLE);
        rst_n = 1'b1;
        // R2 R3 R4 R6 R9: every availability pattern, held for a few cycles
        for (int p = 0; p < 32; p++) begin
            for (int r = 0; r < 4; r++) step(5'(p));
        end
        // Nested preemption: command running, video cuts in, trigger cuts video
        step(5'b10000); step(5'b10000);
        step(5'b11000); step(5'b11001); step(5'b11000);
        step(5'b10000); step(5'b10000); step(5'b00000);
        // Random availability at three densities
        for (int d = 1; d <= 3; d++) begin
            for (int c = 0; c < 1500; c++) begin
                logic [4:0] m;
                for (int i = 0; i < NS; i++) begin
                    if (STB[i]) m[i] = (($urandom % 8) < d);
                    else        m[i] = (($urandom % 4) < d);
                end
                step(m);
            end
        end
        // drain: stream sources only, then idle
        for (int c = 0; c < 40; c++) step(5'b11010);
        for (int c = 0; c < 4; c++) step(5'b00000);
        @(negedge clk);
        check_out();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule